// File: doc/BRIEF.md
# Interrupt Flag Controller with Selectable Pin Polarity

This block keeps two sticky event flags for a receiver control interface and turns them into one interrupt request pin. The radio flag records any change in the 3-bit signal-level code or in the stereo indication. The command flag records the end of a tune or search operation, reported as a single-cycle pulse. Each flag is cleared by a read strobe for the status register that carries it. The radio flag is cleared by reading the radio-status register. The command flag is cleared by reading the tune-status register.

Each flag has its own enable. An enable only decides whether its flag can drive the pin; flags set whether or not they are enabled. A polarity control picks an active-high or an active-low request. While the radio is powered down, the pin is not driven (output enable low), and the radio flag reads back as one. The block also assembles the radio-status byte that the register file returns. All pins are plain level or strobe signals; no data stream passes through the block, so no valid/ready handshake is used.

Top module: `irq_flag_ctrl`

## Requirements
- R1: When `fs_level` or `stereo_ind` differs from its value at the previous clock edge, `radio_flag` is 1 from that edge on, and it stays 1 until it is cleared.
- R2: A change of `fs_boost` alone does not set the radio flag.
- R3: A `rd_radio_stat` strobe at an edge clears the radio flag from that edge on. A `rd_tune_stat` strobe leaves the radio flag unchanged.
- R4: A `cmd_done` pulse sets `cmd_flag` from that edge on. A `rd_tune_stat` strobe clears it, and a `rd_radio_stat` strobe leaves it unchanged.
- R5: If a set event and the clearing strobe of the same flag come at the same edge, the flag ends up 1.
- R6: `radio_ie` and `cmd_ie` do not affect flag setting. The request is active exactly when (radio flag AND `radio_ie`) OR (`cmd_flag` AND `cmd_ie`).
- R7: With power on, `irq_pin` equals the active request when `pol_low`=0, and its inverse when `pol_low`=1.
- R8: With `pwr_on`=0, `irq_oe` is 0, `irq_pin` is 0, and `radio_flag` and bit 7 of `radio_stat_byte` read 1. With `pwr_on`=1, `irq_oe` is 1.
- R9: The bits of `radio_stat_byte` are: bit 7 = radio flag as read, bits 6..5 = 0, bit 4 = `stereo_ind`, bits 3..1 = `fs_level`, bit 0 = `fs_boost`.
- R10: After reset both flags are 0. The first edge after reset does not count as a change, whatever the status inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_on | input | 1 | Radio power control (0 = standby) |
| pol_low | input | 1 | Request polarity (1 = active-low) |
| radio_ie | input | 1 | Lets the radio flag drive the pin |
| cmd_ie | input | 1 | Lets the command flag drive the pin |
| fs_level | input | 3 | Signal-level code |
| stereo_ind | input | 1 | Stereo reception indicator |
| fs_boost | input | 1 | +5 dB level indicator (reported only) |
| cmd_done | input | 1 | One-cycle pulse at the end of a command |
| rd_radio_stat | input | 1 | Read strobe of the radio-status register |
| rd_tune_stat | input | 1 | Read strobe of the tune-status register |
| radio_flag | output | 1 | Radio flag as read by the host |
| cmd_flag | output | 1 | Command-end flag |
| radio_stat_byte | output | 8 | Assembled radio-status byte |
| irq_pin | output | 1 | Interrupt pin level |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The bench drives single-field changes (level only, stereo only, boost only), so it can tell a real status change from a bit that is only reported. It drives read strobes alone, with the other register's strobe, and together with a set event, which shows whether the clear is routed to the right flag and whether a set beats a clear. Random phases flip the enables, the polarity and the power bit while flags are pending. These phases show whether the enables gate only the pin, and whether standby forces the readback and releases the pin.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  localparam int FS_W    = 3;
  localparam int STAT_W  = 8;
  localparam int N_SRC   = 2;
  localparam int SRC_RAD = 0;
  localparam int SRC_CMD = 1;
  localparam int PAD_W   = STAT_W - FS_W - 3;

  typedef struct packed {
    logic            stereo;
    logic [FS_W-1:0] level;
  } rx_status_t;
endpackage

// File: rtl/status_change_det.sv
module status_change_det #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur_i,
  output logic         change_o
);
  logic [W-1:0] prev_q;
  logic         armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= cur_i;
      armed_q <= 1'b1;
    end
  end

  assign change_o = armed_q && (cur_i != prev_q);
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv #(
  parameter int N = 2
) (
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] ie_i,
  input  logic         pwr_on_i,
  input  logic         pol_low_i,
  output logic         pin_o,
  output logic         oe_o
);
  logic active;
  assign active = |(flags_i & ie_i);
  assign oe_o   = pwr_on_i;
  assign pin_o  = pwr_on_i ? (active ^ pol_low_i) : 1'b0;
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irqf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on,
  input  logic              pol_low,
  input  logic              radio_ie,
  input  logic              cmd_ie,
  input  logic [FS_W-1:0]   fs_level,
  input  logic              stereo_ind,
  input  logic              fs_boost,
  input  logic              cmd_done,
  input  logic              rd_radio_stat,
  input  logic              rd_tune_stat,
  output logic              radio_flag,
  output logic              cmd_flag,
  output logic [STAT_W-1:0] radio_stat_byte,
  output logic              irq_pin,
  output logic              irq_oe
);
  rx_status_t       rx_now;
  logic             rx_change;
  logic [N_SRC-1:0] src_set, src_clr, flag_q, src_ie;
  logic             radio_raw;

  assign rx_now.stereo = stereo_ind;
  assign rx_now.level  = fs_level;

  status_change_det #(.W($bits(rx_status_t))) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur_i    (rx_now),
    .change_o (rx_change)
  );

  always_comb begin
    src_set          = '0;
    src_clr          = '0;
    src_ie           = '0;
    src_set[SRC_RAD] = rx_change;
    src_clr[SRC_RAD] = rd_radio_stat;
    src_ie[SRC_RAD]  = radio_ie;
    src_set[SRC_CMD] = cmd_done;
    src_clr[SRC_CMD] = rd_tune_stat;
    src_ie[SRC_CMD]  = cmd_ie;
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_flag
    sticky_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (src_set[g]),
      .clr_i  (src_clr[g]),
      .flag_o (flag_q[g])
    );
  end

  irq_pin_drv #(.N(N_SRC)) u_pin (
    .flags_i   (flag_q),
    .ie_i      (src_ie),
    .pwr_on_i  (pwr_on),
    .pol_low_i (pol_low),
    .pin_o     (irq_pin),
    .oe_o      (irq_oe)
  );

  assign radio_raw       = flag_q[SRC_RAD];
  assign radio_flag      = radio_raw | ~pwr_on;
  assign cmd_flag        = flag_q[SRC_CMD];
  assign radio_stat_byte = {radio_flag, {PAD_W{1'b0}}, stereo_ind, fs_level, fs_boost};
endmodule

// File: rtl/irqf_chk.sv
module irqf_chk
  import irqf_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            pwr_on,
  input logic            pol_low,
  input logic            radio_ie,
  input logic            cmd_ie,
  input logic [FS_W-1:0] fs_level,
  input logic            stereo_ind,
  input logic            cmd_done,
  input logic            rd_radio_stat,
  input logic            rd_tune_stat,
  input logic            radio_raw,
  input logic            radio_flag,
  input logic            cmd_flag,
  input logic            irq_pin,
  input logic            irq_oe
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  // R1: a status change sets the radio flag
  p_rad_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && (fs_level != $past(fs_level) || stereo_ind != $past(stereo_ind))) |=> radio_raw);

  // R3: a radio-status read with no change clears the radio flag
  p_rad_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && rd_radio_stat && $stable(fs_level) && $stable(stereo_ind)) |=> !radio_raw);

  // R4: command end sets the command flag
  p_cmd_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> cmd_flag);

  // R4: a tune-status read with no command end clears it
  p_cmd_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_tune_stat && !cmd_done) |=> !cmd_flag);

  // R5: set beats clear at the same edge
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && rd_tune_stat) |=> cmd_flag);

  // R7: with no enabled source, the pin sits at its idle level
  p_idle_pol_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && !radio_ie && !cmd_ie) |-> (irq_pin == pol_low));

  // R8: standby releases the pin and forces the radio readback
  p_standby_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |-> (!irq_oe && !irq_pin && radio_flag));
endmodule

bind irq_flag_ctrl irqf_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pwr_on        (pwr_on),
  .pol_low       (pol_low),
  .radio_ie      (radio_ie),
  .cmd_ie        (cmd_ie),
  .fs_level      (fs_level),
  .stereo_ind    (stereo_ind),
  .cmd_done      (cmd_done),
  .rd_radio_stat (rd_radio_stat),
  .rd_tune_stat  (rd_tune_stat),
  .radio_raw     (radio_raw),
  .radio_flag    (radio_flag),
  .cmd_flag      (cmd_flag),
  .irq_pin       (irq_pin),
  .irq_oe        (irq_oe)
);

// File: tb/test_irq_flag_ctrl.sv
`timescale 1ns/1ps
module test_irq_flag_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_on = 1'b1, pol_low = 1'b0, radio_ie = 1'b1, cmd_ie = 1'b1;
  logic [2:0] fs_level = 3'd0;
  logic stereo_ind = 1'b0, fs_boost = 1'b0, cmd_done = 1'b0;
  logic rd_radio_stat = 1'b0, rd_tune_stat = 1'b0;
  logic radio_flag, cmd_flag, irq_pin, irq_oe;
  logic [7:0] radio_stat_byte;

  int total = 0, bad = 0;
  bit finished = 0;

  // model state
  logic [3:0] m_prev = '0;
  bit m_armed = 0, m_rq = 0, m_cq = 0;

  always #5 clk = ~clk;

  irq_flag_ctrl i_irq_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .pol_low(pol_low),
    .radio_ie(radio_ie), .cmd_ie(cmd_ie), .fs_level(fs_level),
    .stereo_ind(stereo_ind), .fs_boost(fs_boost), .cmd_done(cmd_done),
    .rd_radio_stat(rd_radio_stat), .rd_tune_stat(rd_tune_stat),
    .radio_flag(radio_flag), .cmd_flag(cmd_flag),
    .radio_stat_byte(radio_stat_byte), .irq_pin(irq_pin), .irq_oe(irq_oe)
  );

  function automatic bit f_rflag();
    return m_rq | ~pwr_on;
  endfunction

  function automatic bit f_pin();
    bit act;
    act = (m_rq & radio_ie) | (m_cq & cmd_ie);
    return pwr_on ? (act ^ pol_low) : 1'b0;
  endfunction

  function automatic logic [7:0] f_byte();
    return {f_rflag(), 2'b00, stereo_ind, fs_level, fs_boost};
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    check("R1/R3 radio_flag", radio_flag, f_rflag());
    check("R4 cmd_flag", cmd_flag, m_cq);
    check("R9 status byte", radio_stat_byte, f_byte());
    check("R7 irq_pin", irq_pin, f_pin());
    check("R8 irq_oe", irq_oe, pwr_on);
  endtask

  // one clock: update model at the edge, compare, then drop pulses
  task automatic cyc();
    bit chg;
    @(posedge clk);
    chg = m_armed && ({stereo_ind, fs_level} != m_prev);
    if (chg) m_rq = 1; else if (rd_radio_stat) m_rq = 0;
    if (cmd_done) m_cq = 1; else if (rd_tune_stat) m_cq = 0;
    m_prev = {stereo_ind, fs_level};
    m_armed = 1;
    #2;
    cmp_all();
    cmd_done = 0; rd_radio_stat = 0; rd_tune_stat = 0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    fs_level = 3'd5; stereo_ind = 1'b1;
    #22;
    check("R10 reset radio_flag", radio_flag, 0);
    check("R10 reset cmd_flag", cmd_flag, 0);
    check("R10 reset irq_pin", irq_pin, 0);
    rst_n = 1'b1;
    cyc(); cyc();
    check("R10 no change at first edge", radio_flag, 0);

    fs_boost = 1'b1; cyc();
    check("R2 boost alone", radio_flag, 0);
    fs_boost = 1'b0; cyc();
    check("R2 boost back", radio_flag, 0);

    fs_level = 3'd2; cyc();
    check("R1 level change", radio_flag, 1);
    cyc();
    check("R1 sticky", radio_flag, 1);
    check("R6 pin active-high", irq_pin, 1);
    pol_low = 1'b1; #1;
    check("R7 pin active-low", irq_pin, 0);
    pol_low = 1'b0;

    rd_tune_stat = 1; cyc();
    check("R3 other read keeps", radio_flag, 1);
    rd_radio_stat = 1; cyc();
    check("R3 read clears", radio_flag, 0);

    stereo_ind = 1'b0; rd_radio_stat = 1; cyc();
    check("R5 radio set wins", radio_flag, 1);
    rd_radio_stat = 1; cyc();

    radio_ie = 0; cmd_ie = 0;
    cmd_done = 1; cyc();
    check("R6 flag sets while disabled", cmd_flag, 1);
    check("R6 pin idle while disabled", irq_pin, 0);
    rd_radio_stat = 1; cyc();
    check("R4 radio read keeps cmd", cmd_flag, 1);
    cmd_ie = 1; #1;
    check("R6 enable passes flag", irq_pin, 1);
    cmd_done = 1; rd_tune_stat = 1; cyc();
    check("R5 cmd set wins", cmd_flag, 1);
    rd_tune_stat = 1; cyc();
    check("R4 tune read clears", cmd_flag, 0);

    pwr_on = 0; #1;
    check("R8 oe low", irq_oe, 0);
    check("R8 pin low", irq_pin, 0);
    check("R8 radio reads one", radio_flag, 1);
    check("R8 byte bit7", radio_stat_byte[7], 1);
    cyc();
    pwr_on = 1; radio_ie = 1;

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(7) == 0) fs_level = 3'($urandom);
      if ($urandom_range(7) == 0) stereo_ind = ~stereo_ind;
      if ($urandom_range(5) == 0) fs_boost = ~fs_boost;
      cmd_done      = ($urandom_range(15) == 0);
      rd_radio_stat = ($urandom_range(7) == 0);
      rd_tune_stat  = ($urandom_range(7) == 0);
      if ($urandom_range(31) == 0) radio_ie = ~radio_ie;
      if ($urandom_range(31) == 0) cmd_ie = ~cmd_ie;
      if ($urandom_range(31) == 0) pol_low = ~pol_low;
      if ($urandom_range(63) == 0) pwr_on = ~pwr_on;
      cyc();
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule